// File: doc/BRIEF.md
# Three-Wire Serial Control Slave

This block is the control-port slave of a receive front end. A master on a three-wire bus (strobe, serial clock, open-drain data with an external pull-up) addresses the device by a 6-bit identity and then reads or writes a small set of 8-bit control registers. The register contents leave the block on dedicated output ports that the rest of the chip uses directly.

A transfer opens with a falling strobe while the serial clock idles high. The first two bits must be `0` then `1`. Six identity bits, a spacer bit, a direction bit (1 = the master writes, 0 = the slave returns data), a 7-bit register address, a second spacer bit and eight data bits follow. Every field is sent MSB first. The spacer/direction/address/spacer/data group may repeat any number of times before the strobe rises again. During a read the slave pulls the data line low for each `0` bit of the returned byte and otherwise leaves it released.

A mode-select pin chooses between the serial bus and parallel control. With the pin low, the three bus pins are passed through as active-low idle, FM-select and sleep controls, and the registers are held at their defaults. All pins pass through two-flop synchronisers into the system clock domain.

Top module: `serial_ctrl_slave`

## Requirements
- R1: A falling strobe starts a transfer and a high strobe ends it. Clock edges seen while the strobe is high change no register and drive nothing.
- R2: Data is sampled on falling serial-clock edges, MSB first. The field order is: start pair `01`, 6-bit identity, spacer, direction bit (1 = write, 0 = read), 7-bit address, spacer, 8 data bits.
- R3: Only identity 0x1F is served. A frame with another identity, or with a start pair other than `01`, is ignored until the strobe rises.
- R4: A write updates the addressed register. Several spacer/direction/address/spacer/data groups inside one strobe window are each carried out.
- R5: During the 8 data bits of a read, the slave pulls the line low exactly for the `0` bits of the register value, MSB first. It releases the line after the last bit and whenever the strobe is high.
- R6: A read of address 0x01 returns 0x1F. Writes to 0x01 have no effect.
- R7: After reset the registers hold 0x3C (address 0x04), 0x0C (address 0x09) and 0x0B (address 0x0C). A write to address 0x00 restores all three defaults.
- R8: Writes to any address other than 0x00, 0x04, 0x09 and 0x0C are discarded. Reads from any address other than 0x01, 0x04, 0x09 and 0x0C return 0x00.
- R9: With the mode pin low, the registers return to their defaults and the data line is released. The idle, FM-select and sleep outputs then follow the strobe, data and clock pins. With the mode pin high, those three outputs are held at 1.
- R10: A strobe falling while the serial clock is low starts no transfer. The slave ignores the bus until the strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| serial_mode | input | 1 | 1 = serial bus, 0 = parallel control |
| pin_stb | input | 1 | Strobe (parallel: idle control) |
| pin_sclk | input | 1 | Serial clock (parallel: sleep control) |
| pin_sdat | input | 1 | Data line as seen on the pad (parallel: FM select) |
| sdat_pull_low | output | 1 | 1 = pull the open-drain data line low |
| blk_ctrl | output | 8 | Register at address 0x04 |
| clkgen_mode | output | 8 | Register at address 0x09 |
| agc_vco_ctrl | output | 8 | Register at address 0x0C |
| par_idle_n | output | 1 | Parallel idle control |
| par_fm_n | output | 1 | Parallel FM-select control |
| par_sleep_n | output | 1 | Parallel sleep control |

## Verification
Every pin passes through two synchroniser flops before the edge detector sees it. A falling serial clock therefore takes effect at the third system-clock edge after the pin changes. A write shows on the register port at that edge. The read drive level changes at that edge, and the line is released at that edge after the final data bit. The bench holds each serial-clock phase for at least four system clocks and samples the line just before the next falling edge, so every result has settled. Mode-pin and parallel-pin effects need three edges; the bench checks them after five.

// File: rtl/ser_ctrl_pkg.sv
package ser_ctrl_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ID_W   = 6;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_ID, ST_SPC1, ST_DIR,
    ST_ADDR, ST_SPC2, ST_DATA, ST_SKIP
  } frame_state_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/frame_engine.sv
module frame_engine
  import ser_ctrl_pkg::*;
#(
  parameter logic [ID_W-1:0] DEV_ID = 6'h1F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              stb_hi,
  input  logic              sclk_hi,
  input  logic              sdat,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              pull_low
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_START = CNT_W'(1);
  localparam logic [CNT_W-1:0] LAST_ID    = CNT_W'(ID_W - 1);
  localparam logic [CNT_W-1:0] LAST_ADDR  = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] LAST_DATA  = CNT_W'(DATA_W - 1);

  frame_state_e      st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-2:0] sh_q, sh_d;
  logic              dir_q, dir_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] rsh_q, rsh_d;
  logic              ract_q, ract_d;
  logic              sclk_prev_q;
  logic              sclk_fall;

  assign sclk_fall = sclk_prev_q & ~sclk_hi;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    dir_d   = dir_q;
    addr_d  = addr_q;
    rsh_d   = rsh_q;
    ract_d  = ract_q;
    wr_en   = 1'b0;
    wr_data = {sh_q, sdat};
    if (!enable) begin
      st_d   = ST_SKIP;
      ract_d = 1'b0;
    end else if (stb_hi) begin
      st_d   = ST_IDLE;
      ract_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          st_d  = sclk_hi ? ST_START : ST_SKIP;
          cnt_d = '0;
        end
        ST_SKIP: st_d = ST_SKIP;
        default: begin
          if (sclk_fall) begin
            sh_d = {sh_q[DATA_W-3:0], sdat};
            unique case (st_q)
              ST_START: begin
                if (cnt_q == LAST_START) begin
                  st_d  = ({sh_q[0], sdat} == 2'b01) ? ST_ID : ST_SKIP;
                  cnt_d = '0;
                end else cnt_d = cnt_q + 1'b1;
              end
              ST_ID: begin
                if (cnt_q == LAST_ID) begin
                  st_d  = ({sh_q[ID_W-2:0], sdat} == DEV_ID) ? ST_SPC1 : ST_SKIP;
                  cnt_d = '0;
                end else cnt_d = cnt_q + 1'b1;
              end
              ST_SPC1: st_d = ST_DIR;
              ST_DIR: begin
                dir_d = sdat;
                st_d  = ST_ADDR;
                cnt_d = '0;
              end
              ST_ADDR: begin
                if (cnt_q == LAST_ADDR) begin
                  addr_d = {sh_q[ADDR_W-2:0], sdat};
                  st_d   = ST_SPC2;
                  cnt_d  = '0;
                end else cnt_d = cnt_q + 1'b1;
              end
              ST_SPC2: begin
                st_d  = ST_DATA;
                cnt_d = '0;
                if (!dir_q) begin
                  rsh_d  = rd_data;
                  ract_d = 1'b1;
                end
              end
              ST_DATA: begin
                rsh_d = {rsh_q[DATA_W-2:0], 1'b0};
                if (cnt_q == LAST_DATA) begin
                  wr_en  = dir_q;
                  ract_d = 1'b0;
                  st_d   = ST_SPC1;
                  cnt_d  = '0;
                end else cnt_d = cnt_q + 1'b1;
              end
              default: st_d = ST_SKIP;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_SKIP;
      cnt_q       <= '0;
      sh_q        <= '0;
      dir_q       <= 1'b0;
      addr_q      <= '0;
      rsh_q       <= '0;
      ract_q      <= 1'b0;
      sclk_prev_q <= 1'b1;
    end else begin
      st_q        <= st_d;
      cnt_q       <= cnt_d;
      sh_q        <= sh_d;
      dir_q       <= dir_d;
      addr_q      <= addr_d;
      rsh_q       <= rsh_d;
      ract_q      <= ract_d;
      sclk_prev_q <= sclk_hi;
    end
  end

  assign acc_addr = addr_q;
  assign pull_low = ract_q & ~rsh_q[DATA_W-1];
endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
  import ser_ctrl_pkg::*;
#(
  parameter int unsigned NREG = 3,
  parameter logic [NREG-1:0][ADDR_W-1:0] REG_ADDR = {7'h0C, 7'h09, 7'h04},
  parameter logic [NREG-1:0][DATA_W-1:0] REG_DEF  = {8'h0B, 8'h0C, 8'h3C},
  parameter logic [ADDR_W-1:0] CLR_ADDR = 7'h00,
  parameter logic [ADDR_W-1:0] ID_ADDR  = 7'h01,
  parameter logic [ID_W-1:0]   DEV_ID   = 6'h1F
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        hold_def,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wr_data,
  output logic [DATA_W-1:0]           rd_data,
  output logic [NREG-1:0][DATA_W-1:0] regs
);
  logic clr_all;
  assign clr_all = hold_def | (wr_en & (addr == CLR_ADDR));

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic ld_en;
    logic [DATA_W-1:0] nxt;
    assign ld_en = clr_all | (wr_en & (addr == REG_ADDR[g]));
    assign nxt   = clr_all ? REG_DEF[g] : wr_data;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     regs[g] <= REG_DEF[g];
      else if (ld_en) regs[g] <= nxt;
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == ID_ADDR) rd_data = DATA_W'(DEV_ID);
    for (int i = 0; i < NREG; i++) begin
      if (addr == REG_ADDR[i]) rd_data = regs[i];
    end
  end
endmodule

// File: rtl/serial_ctrl_slave.sv
module serial_ctrl_slave
  import ser_ctrl_pkg::*;
#(
  parameter logic [ID_W-1:0] DEV_ID = 6'h1F,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              serial_mode,
  input  logic              pin_stb,
  input  logic              pin_sclk,
  input  logic              pin_sdat,
  output logic              sdat_pull_low,
  output logic [DATA_W-1:0] blk_ctrl,
  output logic [DATA_W-1:0] clkgen_mode,
  output logic [DATA_W-1:0] agc_vco_ctrl,
  output logic              par_idle_n,
  output logic              par_fm_n,
  output logic              par_sleep_n
);
  localparam int unsigned NREG = 3;

  logic [1:0] rst_sync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  // bit order: {mode, strobe, clock, data}
  logic [3:0] pins_q;
  logic       mode_q, stb_hi, sclk_hi, sdat_q;
  pin_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0111)) u_sync (
    .clk(clk), .rst_n(rst_i),
    .d({serial_mode, pin_stb, pin_sclk, pin_sdat}),
    .q(pins_q)
  );
  assign {mode_q, stb_hi, sclk_hi, sdat_q} = pins_q;

  logic [ADDR_W-1:0] acc_addr;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [NREG-1:0][DATA_W-1:0] regs;

  frame_engine #(.DEV_ID(DEV_ID)) u_frame (
    .clk(clk), .rst_n(rst_i), .enable(mode_q), .stb_hi(stb_hi),
    .sclk_hi(sclk_hi), .sdat(sdat_q), .rd_data(rd_data),
    .acc_addr(acc_addr), .wr_en(wr_en), .wr_data(wr_data),
    .pull_low(sdat_pull_low)
  );

  ctrl_reg_bank #(.NREG(NREG), .DEV_ID(DEV_ID)) u_regs (
    .clk(clk), .rst_n(rst_i), .hold_def(~mode_q), .wr_en(wr_en),
    .addr(acc_addr), .wr_data(wr_data), .rd_data(rd_data), .regs(regs)
  );

  assign blk_ctrl     = regs[0];
  assign clkgen_mode  = regs[1];
  assign agc_vco_ctrl = regs[2];

  assign par_idle_n  = mode_q | stb_hi;
  assign par_fm_n    = mode_q | sdat_q;
  assign par_sleep_n = mode_q | sclk_hi;
endmodule

// File: rtl/serial_ctrl_slave_chk.sv
module serial_ctrl_slave_chk (
  input logic        clk,
  input logic        rst_i,
  input logic        mode_q,
  input logic        stb_hi,
  input logic        wr_en,
  input logic        sdat_pull_low,
  input logic [23:0] reg_vec
);
  // R5
  stb_release_chk: assert property (@(posedge clk) disable iff (!rst_i)
    stb_hi |=> !sdat_pull_low);
  // R9
  par_release_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !mode_q |=> !sdat_pull_low);
  // R9
  par_defaults_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !mode_q |=> (reg_vec == {8'h0B, 8'h0C, 8'h3C}));
  // R1
  stb_hold_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (mode_q && stb_hi) |=> $stable(reg_vec));
  // R4
  write_only_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (mode_q && !wr_en) |=> $stable(reg_vec));
endmodule

bind serial_ctrl_slave serial_ctrl_slave_chk u_chk (
  .clk(clk), .rst_i(rst_i), .mode_q(mode_q), .stb_hi(stb_hi),
  .wr_en(wr_en), .sdat_pull_low(sdat_pull_low),
  .reg_vec({agc_vco_ctrl, clkgen_mode, blk_ctrl})
);

// File: tb/test_serial_ctrl_slave.sv
module test_serial_ctrl_slave;
  logic clk = 1'b0;
  logic rst_n, mode, m_stb, m_clk, m_dat;
  logic pull_low, idle_n, fm_n, sleep_n;
  logic [7:0] blk, clkm, agc;
  logic line;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  assign line = m_dat & ~pull_low;

  serial_ctrl_slave i_serial_ctrl_slave (
    .clk(clk), .rst_n(rst_n), .serial_mode(mode), .pin_stb(m_stb),
    .pin_sclk(m_clk), .pin_sdat(line), .sdat_pull_low(pull_low),
    .blk_ctrl(blk), .clkgen_mode(clkm), .agc_vco_ctrl(agc),
    .par_idle_n(idle_n), .par_fm_n(fm_n), .par_sleep_n(sleep_n)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    m_dat = b; cyc(4);
    m_clk = 1'b0; cyc(6);
    m_clk = 1'b1; cyc(4);
  endtask

  task automatic field(input logic [7:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) bit_out(v[i]);
  endtask

  task automatic open_frame(input logic [1:0] sp, input logic [5:0] id);
    m_stb = 1'b0; cyc(4);
    field({6'd0, sp}, 2);
    field({2'd0, id}, 6);
  endtask

  task automatic close_frame();
    m_dat = 1'b1; m_stb = 1'b1; cyc(8);
  endtask

  task automatic grp_write(input logic [6:0] a, input logic [7:0] d);
    bit_out(1'b1); bit_out(1'b1); field({1'b0, a}, 7); bit_out(1'b1); field(d, 8);
  endtask

  task automatic grp_read(input logic [6:0] a, output logic [7:0] d);
    bit_out(1'b1); bit_out(1'b0); field({1'b0, a}, 7); bit_out(1'b1);
    for (int i = 7; i >= 0; i--) begin
      m_dat = 1'b1; cyc(4);
      d[i] = line;
      m_clk = 1'b0; cyc(6);
      m_clk = 1'b1; cyc(4);
    end
  endtask

  task automatic do_write(input logic [5:0] id, input logic [6:0] a, input logic [7:0] d);
    open_frame(2'b01, id); grp_write(a, d); close_frame();
  endtask

  task automatic do_read(input logic [6:0] a, output logic [7:0] d);
    open_frame(2'b01, 6'h1F); grp_read(a, d); close_frame();
  endtask

  task automatic t_reset();
    chk("R7 blk default", blk, 8'h3C);
    chk("R7 clk default", clkm, 8'h0C);
    chk("R7 agc default", agc, 8'h0B);
    chk("R5 idle release", {7'd0, pull_low}, 8'h00);
  endtask

  task automatic t_write_read();
    logic [7:0] d;
    do_write(6'h1F, 7'h04, 8'hA5);
    chk("R4 write port", blk, 8'hA5);
    open_frame(2'b01, 6'h1F); grp_read(7'h04, d);
    chk("R5 read bits", d, 8'hA5);
    chk("R5 release after byte", {7'd0, pull_low}, 8'h00);
    close_frame();
    do_read(7'h01, d);
    chk("R6 id read", d, 8'h1F);
  endtask

  task automatic t_multi();
    logic [7:0] d;
    open_frame(2'b01, 6'h1F);
    grp_write(7'h09, 8'h55);
    grp_write(7'h0C, 8'h3A);
    grp_read(7'h09, d);
    close_frame();
    chk("R4 multi clk", clkm, 8'h55);
    chk("R4 multi agc", agc, 8'h3A);
    chk("R2 multi read", d, 8'h55);
  endtask

  task automatic t_reject();
    logic [7:0] d;
    do_write(6'h12, 7'h04, 8'hFF);
    chk("R3 wrong id", blk, 8'hA5);
    open_frame(2'b11, 6'h1F); grp_write(7'h04, 8'h00); close_frame();
    chk("R3 wrong start", blk, 8'hA5);
    do_write(6'h1F, 7'h20, 8'h77);
    do_write(6'h1F, 7'h01, 8'h00);
    chk("R8 unused write", blk ^ clkm ^ agc, 8'hA5 ^ 8'h55 ^ 8'h3A);
    do_read(7'h20, d);
    chk("R8 unused read", d, 8'h00);
    do_read(7'h01, d);
    chk("R6 id unwritable", d, 8'h1F);
  endtask

  task automatic t_strobe_high();
    m_stb = 1'b1;
    field(8'h40 | 8'h1F, 8);
    grp_write(7'h04, 8'h00);
    cyc(4);
    chk("R1 strobe high ignored", blk, 8'hA5);
    chk("R1 no drive", {7'd0, pull_low}, 8'h00);
  endtask

  task automatic t_clk_low_start();
    m_clk = 1'b0; cyc(4);
    m_stb = 1'b0; cyc(4);
    m_clk = 1'b1; cyc(4);
    field({6'd0, 2'b01}, 2); field({2'd0, 6'h1F}, 6);
    grp_write(7'h04, 8'h11);
    close_frame();
    chk("R10 clock-low start", blk, 8'hA5);
  endtask

  task automatic t_clear();
    do_write(6'h1F, 7'h00, 8'h00);
    chk("R7 clear blk", blk, 8'h3C);
    chk("R7 clear clk", clkm, 8'h0C);
    chk("R7 clear agc", agc, 8'h0B);
  endtask

  task automatic t_parallel();
    do_write(6'h1F, 7'h09, 8'h99);
    chk("R9 serial outs high", {5'd0, idle_n, fm_n, sleep_n}, 8'h07);
    mode = 1'b0; cyc(5);
    chk("R9 defaults held", clkm, 8'h0C);
    m_stb = 1'b0; m_dat = 1'b1; m_clk = 1'b0; cyc(5);
    chk("R9 pass-through", {5'd0, idle_n, fm_n, sleep_n}, 8'h02);
    chk("R9 line released", {7'd0, pull_low}, 8'h00);
    m_stb = 1'b1; m_dat = 1'b0; m_clk = 1'b1; cyc(5);
    chk("R9 pass-through 2", {5'd0, idle_n, fm_n, sleep_n}, 8'h05);
    m_dat = 1'b1; cyc(2);
    mode = 1'b1; cyc(6);
    do_write(6'h1F, 7'h0C, 8'hC3);
    chk("R9 serial resumes", agc, 8'hC3);
  endtask

  initial begin
    rst_n = 1'b0; mode = 1'b1; m_stb = 1'b1; m_clk = 1'b1; m_dat = 1'b1;
    cyc(4);
    rst_n = 1'b1;
    cyc(10);
    t_reset();
    t_write_read();
    t_multi();
    t_reject();
    t_strobe_high();
    t_clk_low_start();
    t_clear();
    t_parallel();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule